// File: doc/BRIEF.md
# Conversion and Readout Trigger Timer

This block drives the conversion-start line of a successive-approximation ADC and produces a separate one-cycle trigger that starts a serial readout transaction. The conversion pulse always comes from this timer. The readout trigger comes from one of two timing zones. In the busy-referenced zone, the trigger follows the falling edge of the converter's busy line. In the next-period zone, busy is ignored and the trigger comes from a second free-running counter. That counter has its own period and offset, so the readout rate can be a fraction of the conversion rate when the converter averages blocks of samples internally.

All timing is counted in cycles of the system clock. The conversion period, the pulse width, the readout period, the readout offset and the zone are sampled together when a conversion period starts, so a change made in mid-period never cuts a pulse short. A guard check compares every readout trigger against the conversion phase. A trigger that lands too close to a rising conversion edge sets a sticky error flag.

Top module: `cnvt_trigger_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `cnv_o`, `rd_trig_o` and `err_o` are low.
- R2: Let `en_i` be low, then be sampled high at clock edge E. From then on, `cnv_o` is high for the W cycles that follow edges E, E+1, …, E+W-1, and it is low for the rest of each period. This pattern repeats every P cycles, where P is the conversion period and W the pulse width.
- R3: A programmed period below MIN_PERIOD (default 63 cycles, the 500 ns floor at 125 MHz) runs as MIN_PERIOD. A width of 0 runs as 1. A width of P or more runs as P-1. A readout period below 2 runs as 2. A readout offset at or above the readout period R runs as R-1.
- R4: The configuration inputs are taken only at edge E and at the edge that ends each conversion period. A change made in mid-period first shows in the following period.
- R5: `zone_i` = 1 selects the next-period zone. In this zone the readout counter starts at 0 together with the conversion counter and wraps every R cycles. `rd_trig_o` is high for one cycle each time that counter equals the offset. `busy_i` has no effect on `rd_trig_o`.
- R6: `zone_i` = 0 selects the busy-referenced zone. Let edge k be the first clock edge that samples `busy_i` low after it was high. `rd_trig_o` is then high for the single cycle that begins at edge k+1. No periodic readout triggers occur in this zone.
- R7: In the busy-referenced zone, a trigger issued at conversion phase P-GUARD_CYC or later sets `err_o` one cycle after the trigger. GUARD_CYC defaults to 3, which is 20 ns rounded up. P is the period of the conversion in progress. `err_o` then stays high until reset.
- R8: In the next-period zone, a trigger at phase below GUARD_CYC or at phase P-GUARD_CYC or later sets `err_o`, with the same timing and stickiness as in R7. A trigger at phase P-GUARD_CYC-1 does not set it.
- R9: When `en_i` is sampled low, both outputs are low from the next cycle on and both counters return to phase 0. `err_o` keeps its value. A later enable restarts the pattern of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low holds counters at zero and outputs low |
| zone_i | input | 1 | Readout zone: 0 busy-referenced, 1 next-period |
| cnv_period_i | input | 16 | Conversion period in cycles |
| cnv_width_i | input | 16 | Conversion pulse high time in cycles |
| rd_period_i | input | 16 | Readout trigger period in cycles (next-period zone) |
| rd_offset_i | input | 16 | Readout trigger phase within its period |
| busy_i | input | 1 | Converter busy line, asynchronous |
| cnv_o | output | 1 | Conversion-start pulse |
| rd_trig_o | output | 1 | One-cycle readout transaction trigger |
| err_o | output | 1 | Sticky guard-band violation flag |

## Verification
Two pairs of functions can land in the same cycle, and the bench provokes both.

The first pair is a busy-referenced trigger and a configuration reload. The bench drops busy so that the trigger falls in the last cycle of a conversion period, and it raises the programmed period beforehand. The error must be judged against the period that is ending, so it is expected one cycle later and the next rising edge is expected at the old spacing.

The second pair is a next-period trigger and the rising edge of the conversion pulse. With offset 0, both appear in the same cycle, and this must count as an early guard violation. An offset one cycle short of the late guard band is also run, and it must leave the flag clear.

// File: rtl/cnvt_pkg.sv
package cnvt_pkg;

    // Width of every cycle count handled by the timer.
    parameter int unsigned CW = 16;

    typedef logic [CW-1:0] cyc_t;

    // Readout timing zone; encoding is visible at the zone_i port.
    typedef enum logic {
        ZONE_AFTER_BUSY  = 1'b0,
        ZONE_NEXT_PERIOD = 1'b1
    } rd_zone_e;

    // One complete set of timing settings, swapped atomically.
    typedef struct packed {
        rd_zone_e zone;
        cyc_t     period;
        cyc_t     width;
        cyc_t     rd_period;
        cyc_t     rd_offset;
    } timer_cfg_t;

    localparam cyc_t RD_PERIOD_FLOOR = cyc_t'(2);

    // Bring raw settings into the legal range before they are used.
    function automatic timer_cfg_t sanitize_cfg(input timer_cfg_t raw, input cyc_t min_period);
        timer_cfg_t c;
        c = raw;
        if (raw.period < min_period)
            c.period = min_period;
        if (raw.width == '0)
            c.width = cyc_t'(1);
        else if (raw.width >= c.period)
            c.width = c.period - cyc_t'(1);
        if (raw.rd_period < RD_PERIOD_FLOOR)
            c.rd_period = RD_PERIOD_FLOOR;
        if (raw.rd_offset >= c.rd_period)
            c.rd_offset = c.rd_period - cyc_t'(1);
        return c;
    endfunction

    // True when a readout starting at this conversion phase violates the margins.
    function automatic logic in_guard(input rd_zone_e z, input cyc_t phase,
                                      input cyc_t period, input cyc_t guard);
        logic late;
        logic early;
        late  = (phase >= period - guard);
        early = (phase < guard);
        return late || ((z == ZONE_NEXT_PERIOD) && early);
    endfunction

endpackage

// File: rtl/cnvt_phase_ctr.sv
module cnvt_phase_ctr
    import cnvt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  cyc_t limit_i,
    output cyc_t cnt_o,
    output logic last_o
);

    // Wrap on ">=" so a shorter limit loaded mid-count never overruns.
    assign last_o = (cnt_o >= limit_i - cyc_t'(1));

    always_ff @(posedge clk) begin
        if (rst || !adv_i)
            cnt_o <= '0;
        else if (last_o)
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + cyc_t'(1);
    end

endmodule

// File: rtl/cnvt_busy_fall.sv
module cnvt_busy_fall #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q <= '0;
                else
                    sync_q <= busy_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q <= '0;
                else
                    sync_q <= {sync_q[STAGES-2:0], busy_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= sync_q[STAGES-1];
    end

    // Resetting to low means an idle-high busy line never looks like a fall.
    assign fall_o = prev_q && !sync_q[STAGES-1];

endmodule

// File: rtl/cnvt_guard_mon.sv
module cnvt_guard_mon
    import cnvt_pkg::*;
#(
    parameter int unsigned GUARD_CYC = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     trig_i,
    input  rd_zone_e zone_i,
    input  cyc_t     phase_i,
    input  cyc_t     period_i,
    output logic     err_o
);

    localparam cyc_t GUARD = cyc_t'(GUARD_CYC);

    always_ff @(posedge clk) begin
        if (rst)
            err_o <= 1'b0;
        else if (trig_i && in_guard(zone_i, phase_i, period_i, GUARD))
            err_o <= 1'b1;
    end

endmodule

// File: rtl/cnvt_trigger_timer.sv
module cnvt_trigger_timer
    import cnvt_pkg::*;
#(
    parameter int unsigned MIN_PERIOD  = 63,
    parameter int unsigned GUARD_CYC   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       zone_i,
    input  logic [CW-1:0] cnv_period_i,
    input  logic [CW-1:0] cnv_width_i,
    input  logic [CW-1:0] rd_period_i,
    input  logic [CW-1:0] rd_offset_i,
    input  logic       busy_i,
    output logic       cnv_o,
    output logic       rd_trig_o,
    output logic       err_o
);

    localparam cyc_t MIN_P = cyc_t'(MIN_PERIOD);

    timer_cfg_t raw_cfg;
    timer_cfg_t act_cfg;
    logic       run_q;
    logic       adv;
    logic       reload;
    cyc_t       cnv_cnt;
    cyc_t       rd_cnt;
    logic       cnv_last;
    logic       rd_last;
    logic       busy_fall;
    logic       periodic_hit;

    assign raw_cfg = '{zone:      rd_zone_e'(zone_i),
                       period:    cnv_period_i,
                       width:     cnv_width_i,
                       rd_period: rd_period_i,
                       rd_offset: rd_offset_i};

    // Counters advance only from the second enabled cycle; the first cycle is phase 0.
    assign adv    = en_i && run_q;
    assign reload = !run_q || (adv && cnv_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            act_cfg <= sanitize_cfg('0, MIN_P);
        end else begin
            run_q <= en_i;
            if (reload || !en_i)
                act_cfg <= sanitize_cfg(raw_cfg, MIN_P);
        end
    end

    cnvt_phase_ctr u_cnv_ctr (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv),
        .limit_i (act_cfg.period),
        .cnt_o   (cnv_cnt),
        .last_o  (cnv_last)
    );

    cnvt_phase_ctr u_rd_ctr (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv),
        .limit_i (act_cfg.rd_period),
        .cnt_o   (rd_cnt),
        .last_o  (rd_last)
    );

    cnvt_busy_fall #(.STAGES(SYNC_STAGES)) u_busy (
        .clk    (clk),
        .rst    (rst),
        .busy_i (busy_i),
        .fall_o (busy_fall)
    );

    assign periodic_hit = (rd_cnt == act_cfg.rd_offset);

    assign cnv_o     = run_q && (cnv_cnt < act_cfg.width);
    assign rd_trig_o = run_q && ((act_cfg.zone == ZONE_NEXT_PERIOD) ? periodic_hit : busy_fall);

    cnvt_guard_mon #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (rd_trig_o),
        .zone_i   (act_cfg.zone),
        .phase_i  (cnv_cnt),
        .period_i (act_cfg.period),
        .err_o    (err_o)
    );

    // The readout wrap flag is only needed inside its own counter.
    logic unused_rd_last;
    assign unused_rd_last = rd_last;

endmodule

// File: rtl/cnvt_trigger_timer_sva.sv
module cnvt_trigger_timer_sva
    import cnvt_pkg::*;
#(
    parameter int unsigned MIN_PERIOD = 63
) (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic cnv_o,
    input logic rd_trig_o,
    input logic err_o,
    input cyc_t act_period
);

    logic [15:0] hi_cnt;
    logic [15:0] gap;
    logic        seen;
    logic        cnv_prev;
    logic        rise;

    assign rise = cnv_o && !cnv_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt   <= '0;
            gap      <= '0;
            seen     <= 1'b0;
            cnv_prev <= 1'b0;
        end else begin
            cnv_prev <= cnv_o;
            hi_cnt   <= cnv_o ? hi_cnt + 16'd1 : 16'd0;
            if (!en_i) begin
                seen <= 1'b0;
                gap  <= '0;
            end else if (rise) begin
                seen <= 1'b1;
                gap  <= '0;
            end else if (gap != 16'hFFFF) begin
                gap <= gap + 16'd1;
            end
        end
    end

    a_r9_disable_quiets: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!cnv_o && !rd_trig_o));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    a_r8_err_after_trigger: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(rd_trig_o));

    a_r5_trigger_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_trig_o |=> !rd_trig_o);

    a_r3_width_below_period: assert property (@(posedge clk) disable iff (rst)
        cnv_o |-> (32'(hi_cnt) < 32'(act_period)));

    a_r3_min_spacing: assert property (@(posedge clk) disable iff (rst)
        (rise && seen) |-> (32'(gap) >= MIN_PERIOD - 1));

endmodule

bind cnvt_trigger_timer cnvt_trigger_timer_sva #(.MIN_PERIOD(MIN_PERIOD)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .cnv_o      (cnv_o),
    .rd_trig_o  (rd_trig_o),
    .err_o      (err_o),
    .act_period (act_cfg.period)
);

// File: tb/tb_cnvt_trigger_timer.sv
module tb_cnvt_trigger_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        zone = 1'b0;
    logic [15:0] per = '0;
    logic [15:0] wid = '0;
    logic [15:0] rper = '0;
    logic [15:0] roff = '0;
    logic        busy = 1'b0;
    logic        cnv_o;
    logic        rd_trig_o;
    logic        err_o;

    always #4 clk = ~clk;

    cnvt_trigger_timer dut (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .zone_i       (zone),
        .cnv_period_i (per),
        .cnv_width_i  (wid),
        .rd_period_i  (rper),
        .rd_offset_i  (roff),
        .busy_i       (busy),
        .cnv_o        (cnv_o),
        .rd_trig_o    (rd_trig_o),
        .err_o        (err_o)
    );

    int    cyc = 0;
    int    checks = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    c0 = 0;
    int    exp_cnv_q[$];
    int    exp_w_q[$];
    int    exp_rd_q[$];
    string tag_cnv = "R2";
    string tag_rd = "R5";
    int    hi_len = 0;
    int    cur_w = 0;
    logic  cnv_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compares observed edges and pulses against the scoreboard queues.
    always @(negedge clk) begin
        int e;
        if (rst || done) begin
            cnv_prev = 1'b0;
            hi_len   = 0;
        end else begin
            if (cnv_o && !cnv_prev) begin
                if (exp_cnv_q.size() == 0) begin
                    chk(1'b0, tag_cnv, cyc, -1);
                    cur_w = -1;
                end else begin
                    e     = exp_cnv_q.pop_front();
                    cur_w = exp_w_q.pop_front();
                    chk(cyc == e, tag_cnv, cyc, e);
                end
                hi_len = 1;
            end else if (cnv_o) begin
                hi_len++;
            end
            if (!cnv_o && cnv_prev)
                chk(hi_len == cur_w, tag_cnv, hi_len, cur_w);
            if (rd_trig_o) begin
                if (exp_rd_q.size() == 0) begin
                    chk(1'b0, tag_rd, cyc, -1);
                end else begin
                    e = exp_rd_q.pop_front();
                    chk(cyc == e, tag_rd, cyc, e);
                end
            end
            cnv_prev = cnv_o;
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finish_up();
        end
    end

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic set_cfg(bit z, int p, int w, int r, int o);
        zone = z;
        per  = 16'(p);
        wid  = 16'(w);
        rper = 16'(r);
        roff = 16'(o);
    endtask

    task automatic push_cnv(int t, int w);
        exp_cnv_q.push_back(t);
        exp_w_q.push_back(w);
    endtask

    task automatic push_rd(int t);
        exp_rd_q.push_back(t);
    endtask

    task automatic push_train(int p, int w, int nc);
        for (int k = 0; c0 + 1 + k * p <= c0 + nc; k++)
            push_cnv(c0 + 1 + k * p, w);
    endtask

    task automatic start_run();
        @(negedge clk);
        en = 1'b1;
        c0 = cyc;
    endtask

    task automatic stop_run(int t_end);
        wait_until(t_end);
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cnv_o && !rd_trig_o, "R9 outputs low while disabled", int'(cnv_o) + int'(rd_trig_o), 0);
        chk(exp_cnv_q.size() == 0, "R2 missing conversion edges", exp_cnv_q.size(), 0);
        chk(exp_rd_q.size() == 0, "R5 missing readout triggers", exp_rd_q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        chk(cnv_o == 1'b0, "R1 cnv_o in reset", int'(cnv_o), 0);
        chk(rd_trig_o == 1'b0, "R1 rd_trig_o in reset", int'(rd_trig_o), 0);
        chk(err_o == 1'b0, "R1 err_o in reset", int'(err_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cnv_o && !rd_trig_o && !err_o, "R1 idle after reset", int'(cnv_o | rd_trig_o | err_o), 0);
    endtask

    initial begin
        do_reset();

        // Next-period zone, busy toggled and ignored (R2, R5)
        tag_cnv = "R2"; tag_rd = "R5";
        set_cfg(1'b1, 100, 10, 200, 50);
        start_run();
        push_train(100, 10, 400);
        push_rd(c0 + 51);
        push_rd(c0 + 251);
        wait_until(c0 + 20);  busy = 1'b1;
        wait_until(c0 + 40);  busy = 1'b0;
        wait_until(c0 + 43);
        chk(rd_trig_o == 1'b0, "R5 busy fall ignored", int'(rd_trig_o), 0);
        wait_until(c0 + 60);  busy = 1'b1;
        wait_until(c0 + 120); busy = 1'b0;
        stop_run(c0 + 400);
        chk(err_o == 1'b0, "R8 no guard error mid-period", int'(err_o), 0);

        // Decimated readout: one trigger per four conversions (R5)
        set_cfg(1'b1, 64, 5, 256, 70);
        start_run();
        push_train(64, 5, 512);
        push_rd(c0 + 71);
        push_rd(c0 + 327);
        stop_run(c0 + 512);

        // Clamping of short period and zero width, busy zone idle (R3, R6)
        tag_cnv = "R3"; tag_rd = "R6";
        busy = 1'b1;
        set_cfg(1'b0, 10, 0, 1, 5);
        start_run();
        push_train(63, 1, 189);
        stop_run(c0 + 189);

        // Clamping of oversize width and offset (R3)
        tag_rd = "R3";
        set_cfg(1'b1, 70, 200, 100, 250);
        start_run();
        push_train(70, 69, 280);
        push_rd(c0 + 100);
        push_rd(c0 + 200);
        stop_run(c0 + 280);
        chk(err_o == 1'b0, "R3 clamped offset outside guard", int'(err_o), 0);

        // Mid-period change applies from the next period (R4)
        tag_cnv = "R4"; tag_rd = "R4";
        busy = 1'b1;
        set_cfg(1'b0, 80, 8, 10, 3);
        start_run();
        push_cnv(c0 + 1, 8);
        push_cnv(c0 + 81, 20);
        push_cnv(c0 + 201, 20);
        push_cnv(c0 + 321, 20);
        wait_until(c0 + 30);
        per = 16'd120;
        wid = 16'd20;
        stop_run(c0 + 440);

        // Busy-referenced readout; late fall coinciding with a reload (R6, R7)
        tag_cnv = "R4"; tag_rd = "R6";
        busy = 1'b1;
        set_cfg(1'b0, 100, 10, 10, 3);
        start_run();
        push_cnv(c0 + 1, 10);
        push_cnv(c0 + 101, 10);
        push_cnv(c0 + 201, 10);
        push_cnv(c0 + 351, 10);
        push_rd(c0 + 42);
        push_rd(c0 + 200);
        wait_until(c0 + 40);  busy = 1'b0;
        wait_until(c0 + 45);
        chk(err_o == 1'b0, "R7 early busy fall is legal", int'(err_o), 0);
        wait_until(c0 + 50);  busy = 1'b1;
        wait_until(c0 + 150); per = 16'd150;
        wait_until(c0 + 198); busy = 1'b0;
        wait_until(c0 + 199);
        chk(err_o == 1'b0, "R7 flag clear before late trigger", int'(err_o), 0);
        wait_until(c0 + 201);
        chk(err_o == 1'b1, "R7 late trigger judged on ending period", int'(err_o), 1);
        stop_run(c0 + 450);
        chk(err_o == 1'b1, "R9 error kept while disabled", int'(err_o), 1);
        do_reset();

        // Next-period trigger on the conversion edge (R8 early side)
        tag_cnv = "R2"; tag_rd = "R8";
        set_cfg(1'b1, 64, 4, 64, 0);
        start_run();
        push_train(64, 4, 128);
        push_rd(c0 + 1);
        push_rd(c0 + 65);
        wait_until(c0 + 1);
        chk(err_o == 1'b0, "R8 flag clear at coincident trigger", int'(err_o), 0);
        wait_until(c0 + 2);
        chk(err_o == 1'b1, "R8 early guard violation", int'(err_o), 1);
        stop_run(c0 + 128);
        do_reset();

        // Just outside the late guard band (R8 boundary)
        set_cfg(1'b1, 64, 4, 64, 60);
        start_run();
        push_train(64, 4, 128);
        push_rd(c0 + 61);
        push_rd(c0 + 125);
        stop_run(c0 + 128);
        chk(err_o == 1'b0, "R8 phase P-G-1 is legal", int'(err_o), 0);

        // Inside the late guard band (R8)
        set_cfg(1'b1, 64, 4, 64, 62);
        start_run();
        push_train(64, 4, 128);
        push_rd(c0 + 63);
        push_rd(c0 + 127);
        wait_until(c0 + 63);
        chk(err_o == 1'b0, "R8 flag clear before late trigger", int'(err_o), 0);
        wait_until(c0 + 64);
        chk(err_o == 1'b1, "R8 late guard violation", int'(err_o), 1);
        stop_run(c0 + 128);

        finish_up();
    end

endmodule